// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

This block turns a 32-bit IEEE single-precision value into a signed or unsigned integer of 32 or 64 bits. The rounding mode arrives with each operand as a 3-bit code. Values that cannot be represented are clipped to fixed corner values; they do not wrap. Every result carries two flags. The invalid flag marks a clipped or NaN input. The inexact flag marks a result that differs from the input value.

Operands enter through a valid/ready stream together with their mode and format selects. Results leave through a second valid/ready stream. An operand is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and its flags hold still. Stalls travel back through two register stages. When both stages are full and the output is stalled, `in_ready` drops. With no stalls, one operand is accepted on every cycle.

A 64-bit output carries every result. A 32-bit result is sign-extended into the upper half, and this applies to unsigned 32-bit results too. The dynamic rounding mode is resolved upstream of this block.

Top module: `fp2int_sat`

## Requirements
- R1: `in_mode` picks the rounding: 000 nearest with ties to even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 nearest with ties away from zero.
- R2: The codes 101, 110 and 111 round toward zero.
- R3: A signed 32-bit result (`in_signed`=1, `in_wide`=0) is clipped to -2^31 for values below that range or -inf, and to 2^31-1 for values above it or +inf.
- R4: An unsigned 32-bit result (`in_signed`=0, `in_wide`=0) is clipped to 0 for negative out-of-range values or -inf, and to 2^32-1 for values above the range or +inf.
- R5: A 64-bit result (`in_wide`=1) is clipped to -2^63 or 2^63-1 when signed, and to 0 or 2^64-1 when unsigned.
- R6: A NaN of either sign and any payload yields the largest positive value of the selected format.
- R7: `out_nv` is set for every clipped result and every NaN, and is clear otherwise.
- R8: `out_nx` is set when the rounded integer differs from the input value, but never when `out_nv` is set.
- R9: A 32-bit result fills bits 63:32 with copies of bit 31, for unsigned results as well.
- R10: Range is judged after rounding. A negative value that rounds to 0 is a valid unsigned result and raises only `out_nx`. One that rounds to -1 is clipped.
- R11: Zero and subnormal inputs give 0, or +1 or -1 under directed rounding away from zero. Inexact is raised whenever the input is nonzero, and -0.0 gives 0 with no flags.
- R12: A result held with `out_valid` high and `out_ready` low stays unchanged. With both stages full and the output stalled, `in_ready` is low.
- R13: With no stall, `out_valid` rises on the second rising edge after the operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_bits | input | 32 | Single-precision operand |
| in_mode | input | 3 | Rounding mode code |
| in_signed | input | 1 | 1 for a signed result, 0 for unsigned |
| in_wide | input | 1 | 1 for a 64-bit result, 0 for 32-bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Integer result, with 32-bit results sign-extended |
| out_nv | output | 1 | Invalid: result clipped or input was NaN |
| out_nx | output | 1 | Inexact: rounding changed the value |

## Verification
Rounding and range clipping can act on the same operand in the same cycle. A round-up carry can push a magnitude just past a limit, and then the inexact flag from rounding must give way to the invalid flag. The bench provokes this with a negative fraction under unsigned conversion, where one rounding outcome stays at zero and the other reaches -1. It expects only inexact in the first case and only invalid with a zero result in the second. It also stalls the output while a second operand waits in the middle stage. It then judges that the held result stays steady, that input acceptance stops, and that both results come out in order.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = 127;
  localparam int INT_W  = 64;
  localparam int HALF_W = INT_W / 2;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'b000,
    RM_ZERO      = 3'b001,
    RM_DOWN      = 3'b010,
    RM_UP        = 3'b011,
    RM_NEAR_MAX  = 3'b100
  } rmode_e;

  typedef struct packed {
    logic             is_nan;
    logic             huge;
    logic             sign;
    logic [INT_W-1:0] ipart;
    logic             rbit;
    logic             sbit;
  } unpk_t;
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
  import fp2int_pkg::*;
(
  input  logic [FP_W-1:0] bits_i,
  output unpk_t           u_o
);
  localparam int LSH_BASE = BIAS + FRAC_W;
  localparam int RS_MAX   = SIG_W + 2;
  localparam int HUGE_EXP = BIAS + INT_W;
  localparam int WIDE_W   = SIG_W + RS_MAX;

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W-1:0]  e_eff;
  logic [SIG_W-1:0]  sig;
  logic [EXP_W-1:0]  lamt;
  logic [EXP_W-1:0]  ramt;
  logic [WIDE_W-1:0] wide;

  assign ex    = bits_i[FP_W-2 -: EXP_W];
  assign frac  = bits_i[FRAC_W-1:0];
  assign e_eff = (ex == '0) ? EXP_W'(1) : ex;
  assign sig   = {(ex != '0), frac};

  always_comb begin
    u_o        = '0;
    u_o.sign   = bits_i[FP_W-1];
    u_o.is_nan = (&ex) && (frac != '0);
    u_o.huge   = !u_o.is_nan && ((&ex) || (ex >= EXP_W'(HUGE_EXP)));
    lamt = '0;
    ramt = '0;
    wide = '0;
    if (e_eff >= EXP_W'(LSH_BASE)) begin
      lamt    = e_eff - EXP_W'(LSH_BASE);
      u_o.ipart = INT_W'(sig) << lamt;
    end else begin
      ramt = EXP_W'(LSH_BASE) - e_eff;
      if (ramt > EXP_W'(RS_MAX)) ramt = EXP_W'(RS_MAX);
      wide      = {sig, {RS_MAX{1'b0}}} >> ramt;
      u_o.ipart = INT_W'(wide[WIDE_W-1:RS_MAX]);
      u_o.rbit  = wide[RS_MAX-1];
      u_o.sbit  = |wide[RS_MAX-2:0];
    end
  end
endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
  import fp2int_pkg::*;
(
  input  unpk_t          u_i,
  input  logic [2:0]     mode_i,
  output logic [INT_W:0] mag_o,
  output logic           inexact_o
);
  logic inc;
  logic frac_nz;

  assign frac_nz = u_i.rbit | u_i.sbit;

  always_comb begin
    case (rmode_e'(mode_i))
      RM_NEAR_EVEN: inc = u_i.rbit & (u_i.sbit | u_i.ipart[0]);
      RM_ZERO:      inc = 1'b0;
      RM_DOWN:      inc = u_i.sign & frac_nz;
      RM_UP:        inc = ~u_i.sign & frac_nz;
      RM_NEAR_MAX:  inc = u_i.rbit;
      default:      inc = 1'b0;
    endcase
  end

  assign mag_o     = {1'b0, u_i.ipart} + (INT_W+1)'(inc);
  assign inexact_o = frac_nz;
endmodule

// File: rtl/fp2int_clip.sv
module fp2int_clip
  import fp2int_pkg::*;
(
  input  logic             is_nan_i,
  input  logic             huge_i,
  input  logic             sign_i,
  input  logic [INT_W:0]   mag_i,
  input  logic             inexact_i,
  input  logic             signed_i,
  input  logic             wide_i,
  output logic [INT_W-1:0] res_o,
  output logic             nv_o,
  output logic             nx_o
);
  localparam logic [INT_W:0] SW_POS = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] SW_NEG = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W:0] UW_POS = {1'b0, {INT_W{1'b1}}};
  localparam logic [INT_W:0] SN_POS = {{(INT_W-HALF_W+2){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [INT_W:0] SN_NEG = {{(INT_W-HALF_W+1){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [INT_W:0] UN_POS = {{(INT_W-HALF_W+1){1'b0}}, {HALF_W{1'b1}}};

  logic [INT_W:0]   pos_lim, neg_lim;
  logic [INT_W-1:0] max_res, min_res;
  logic [INT_W-1:0] val;
  logic             over;

  always_comb begin
    case ({signed_i, wide_i})
      2'b11: begin
        pos_lim = SW_POS; neg_lim = SW_NEG;
        max_res = {1'b0, {(INT_W-1){1'b1}}};
        min_res = {1'b1, {(INT_W-1){1'b0}}};
      end
      2'b10: begin
        pos_lim = SN_POS; neg_lim = SN_NEG;
        max_res = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
        min_res = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
      end
      2'b01: begin
        pos_lim = UW_POS; neg_lim = '0;
        max_res = '1; min_res = '0;
      end
      default: begin
        pos_lim = UN_POS; neg_lim = '0;
        max_res = '1; min_res = '0;
      end
    endcase
  end

  always_comb begin
    over = huge_i | (sign_i ? (mag_i > neg_lim) : (mag_i > pos_lim));
    val  = sign_i ? -mag_i[INT_W-1:0] : mag_i[INT_W-1:0];
    if (!wide_i) val = {{HALF_W{val[HALF_W-1]}}, val[HALF_W-1:0]};
    if (is_nan_i)             res_o = max_res;
    else if (over && sign_i)  res_o = min_res;
    else if (over)            res_o = max_res;
    else                      res_o = val;
    nv_o = is_nan_i | over;
    nx_o = inexact_i & ~nv_o;
  end
endmodule

// File: rtl/fp2int_sat.sv
module fp2int_sat
  import fp2int_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_bits,
  input  logic [2:0]       in_mode,
  input  logic             in_signed,
  input  logic             in_wide,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [INT_W-1:0] out_data,
  output logic             out_nv,
  output logic             out_nx
);
  unpk_t            unp_d, s1_u;
  logic             s1_valid;
  logic [2:0]       s1_mode;
  logic             s1_signed, s1_wide;
  logic             out_adv, s1_adv;
  logic [INT_W:0]   rnd_mag;
  logic             rnd_inexact;
  logic [INT_W-1:0] clip_res;
  logic             clip_nv, clip_nx;
  logic             out_wide_q;

  assign out_adv  = !out_valid || out_ready;
  assign s1_adv   = !s1_valid || out_adv;
  assign in_ready = s1_adv;

  fp2int_unpack u_unpack (
    .bits_i (in_bits),
    .u_o    (unp_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_u      <= '0;
      s1_mode   <= '0;
      s1_signed <= 1'b0;
      s1_wide   <= 1'b0;
    end else if (s1_adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_u      <= unp_d;
        s1_mode   <= in_mode;
        s1_signed <= in_signed;
        s1_wide   <= in_wide;
      end
    end
  end

  fp2int_round u_round (
    .u_i       (s1_u),
    .mode_i    (s1_mode),
    .mag_o     (rnd_mag),
    .inexact_o (rnd_inexact)
  );

  fp2int_clip u_clip (
    .is_nan_i  (s1_u.is_nan),
    .huge_i    (s1_u.huge),
    .sign_i    (s1_u.sign),
    .mag_i     (rnd_mag),
    .inexact_i (rnd_inexact),
    .signed_i  (s1_signed),
    .wide_i    (s1_wide),
    .res_o     (clip_res),
    .nv_o      (clip_nv),
    .nx_o      (clip_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_nv     <= 1'b0;
      out_nx     <= 1'b0;
      out_wide_q <= 1'b0;
    end else if (out_adv) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data   <= clip_res;
        out_nv     <= clip_nv;
        out_nx     <= clip_nx;
        out_wide_q <= s1_wide;
      end
    end
  end

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_nv) && $stable(out_nx));

  // R12
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |=> s1_valid && $stable(s1_u) && $stable(s1_mode));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_nv && out_nx));

  // R9
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wide_q |-> out_data[INT_W-1:HALF_W] == {HALF_W{out_data[HALF_W-1]}});
endmodule

// File: tb/fp2int_sat_tb.sv
module fp2int_sat_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_bits = '0;
  logic [2:0]  in_mode = '0;
  logic        in_signed = 1'b0;
  logic        in_wide = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_nv, out_nx;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp2int_sat u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_bits(in_bits),
    .in_mode(in_mode), .in_signed(in_signed), .in_wide(in_wide),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_nv(out_nv), .out_nx(out_nx)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_res(input string tag, input logic [63:0] d, input logic nv, input logic nx,
                           input logic [63:0] ed, input logic env, input logic enx);
    checks++;
    if (d !== ed || nv !== env || nx !== enx) begin
      failures++;
      $display("FAIL %s actual=%h nv=%0b nx=%0b expected=%h nv=%0b nx=%0b",
               tag, d, nv, nx, ed, env, enx);
    end
  endtask

  task automatic xfer(input string tag, input logic [31:0] b, input logic [2:0] m,
                      input logic sg, input logic wd,
                      input logic [63:0] ed, input logic env, input logic enx);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_bits = b; in_mode = m; in_signed = sg; in_wide = wd;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 0; n < 10 && !out_valid; n++) @(negedge clk);
    check_res(tag, out_data, out_nv, out_nx, ed, env, enx);
  endtask

  task automatic t_reset;
    check_bit("reset out_valid R13", out_valid, 1'b0);
    check_bit("reset in_ready R12", in_ready, 1'b1);
  endtask

  task automatic t_round_modes;
    xfer("R1 1.5 even", 32'h3FC00000, 3'b000, 1, 0, 64'd2, 0, 1);
    xfer("R1 2.5 even", 32'h40200000, 3'b000, 1, 0, 64'd2, 0, 1);
    xfer("R1 2.5 away", 32'h40200000, 3'b100, 1, 0, 64'd3, 0, 1);
    xfer("R1 -1.5 down", 32'hBFC00000, 3'b010, 1, 0, 64'hFFFFFFFFFFFFFFFE, 0, 1);
    xfer("R1 -1.5 up", 32'hBFC00000, 3'b011, 1, 0, 64'hFFFFFFFFFFFFFFFF, 0, 1);
    xfer("R1 -1.5 zero", 32'hBFC00000, 3'b001, 1, 0, 64'hFFFFFFFFFFFFFFFF, 0, 1);
    xfer("R1 0.7 down", 32'h3F333333, 3'b010, 1, 1, 64'd0, 0, 1);
    xfer("R1 0.7 up", 32'h3F333333, 3'b011, 1, 1, 64'd1, 0, 1);
    xfer("R8 100 exact", 32'h42C80000, 3'b000, 1, 0, 64'd100, 0, 0);
  endtask

  task automatic t_reserved;
    xfer("R2 1.5 code101", 32'h3FC00000, 3'b101, 1, 0, 64'd1, 0, 1);
    xfer("R2 -1.5 code110", 32'hBFC00000, 3'b110, 1, 0, 64'hFFFFFFFFFFFFFFFF, 0, 1);
    xfer("R2 2.5 code111", 32'h40200000, 3'b111, 1, 1, 64'd2, 0, 1);
  endtask

  task automatic t_signed32;
    xfer("R3 2^31 clip", 32'h4F000000, 3'b000, 1, 0, 64'h000000007FFFFFFF, 1, 0);
    xfer("R3 -2^31 fits", 32'hCF000000, 3'b000, 1, 0, 64'hFFFFFFFF80000000, 0, 0);
    xfer("R3 -inf", 32'hFF800000, 3'b000, 1, 0, 64'hFFFFFFFF80000000, 1, 0);
    xfer("R7 3e9 signed32", 32'h4F32D05E, 3'b000, 1, 0, 64'h000000007FFFFFFF, 1, 0);
  endtask

  task automatic t_unsigned32;
    xfer("R9 3e9 unsigned32", 32'h4F32D05E, 3'b000, 0, 0, 64'hFFFFFFFFB2D05E00, 0, 0);
    xfer("R4 +inf", 32'h7F800000, 3'b000, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, 0);
    xfer("R4 2^32 clip", 32'h4F800000, 3'b001, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, 0);
    xfer("R4 -1.0", 32'hBF800000, 3'b000, 0, 0, 64'd0, 1, 0);
    xfer("R9 max fits", 32'h4F7FFFFF, 3'b000, 0, 0, 64'hFFFFFFFFFFFFFF00, 0, 0);
  endtask

  task automatic t_wide;
    xfer("R5 3e9 signed64", 32'h4F32D05E, 3'b000, 1, 1, 64'd3000000000, 0, 0);
    xfer("R5 2^63 signed", 32'h5F000000, 3'b000, 1, 1, 64'h7FFFFFFFFFFFFFFF, 1, 0);
    xfer("R5 2^63 unsigned", 32'h5F000000, 3'b000, 0, 1, 64'h8000000000000000, 0, 0);
    xfer("R5 2^64 unsigned", 32'h5F800000, 3'b000, 0, 1, 64'hFFFFFFFFFFFFFFFF, 1, 0);
    xfer("R5 -inf signed", 32'hFF800000, 3'b000, 1, 1, 64'h8000000000000000, 1, 0);
    xfer("R5 -1 unsigned", 32'hBF800000, 3'b000, 0, 1, 64'd0, 1, 0);
  endtask

  task automatic t_nan;
    xfer("R6 nan s32", 32'h7FC00000, 3'b000, 1, 0, 64'h000000007FFFFFFF, 1, 0);
    xfer("R6 -nan u64", 32'hFFC00001, 3'b010, 0, 1, 64'hFFFFFFFFFFFFFFFF, 1, 0);
    xfer("R6 nan s64", 32'h7F800001, 3'b011, 1, 1, 64'h7FFFFFFFFFFFFFFF, 1, 0);
    xfer("R6 -nan u32", 32'hFFFFFFFF, 3'b001, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, 0);
  endtask

  task automatic t_after_round;
    xfer("R10 -0.5 even u32", 32'hBF000000, 3'b000, 0, 0, 64'd0, 0, 1);
    xfer("R10 -0.7 even u32", 32'hBF333333, 3'b000, 0, 0, 64'd0, 1, 0);
    xfer("R10 -0.7 zero u64", 32'hBF333333, 3'b001, 0, 1, 64'd0, 0, 1);
  endtask

  task automatic t_small;
    xfer("R11 sub up", 32'h00000001, 3'b011, 1, 0, 64'd1, 0, 1);
    xfer("R11 sub even", 32'h00000001, 3'b000, 1, 0, 64'd0, 0, 1);
    xfer("R11 -sub down", 32'h80000001, 3'b010, 1, 1, 64'hFFFFFFFFFFFFFFFF, 0, 1);
    xfer("R11 -0.0", 32'h80000000, 3'b010, 0, 0, 64'd0, 0, 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_bits = 32'h42C80000; in_mode = 3'b000; in_signed = 1; in_wide = 0;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R13 not after first edge", out_valid, 1'b0);
    @(negedge clk);
    check_bit("R13 valid after second edge", out_valid, 1'b1);
    check_res("R13 data", out_data, out_nv, out_nx, 64'd100, 0, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_bits = 32'h42C80000; in_mode = 3'b000; in_signed = 1; in_wide = 0;
    @(negedge clk);
    in_bits = 32'hCF000000;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R12 in_ready low when full", in_ready, 1'b0);
    check_res("R12 first held", out_data, out_nv, out_nx, 64'd100, 0, 0);
    repeat (3) @(negedge clk);
    check_bit("R12 still valid", out_valid, 1'b1);
    check_res("R12 first stable", out_data, out_nv, out_nx, 64'd100, 0, 0);
    out_ready = 1'b1;
    @(negedge clk);
    check_bit("R12 second valid", out_valid, 1'b1);
    check_res("R12 second in order", out_data, out_nv, out_nx, 64'hFFFFFFFF80000000, 0, 0);
    @(negedge clk);
    check_bit("R12 drained", out_valid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_round_modes();
    t_reserved();
    t_signed32();
    t_unsigned32();
    t_wide();
    t_nan();
    t_after_round();
    t_small();
    t_latency();
    @(negedge clk);
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule